// File: doc/BRIEF.md
# Cycle-Steal Word/Character Packer

This block sits between a 16-bit word memory and an 8-bit character stream. Software, or a control-block reader, starts a transfer by giving a direction, a first memory address and a character count. The block then borrows single memory cycles, known as cycle steals, to fetch or store whole words. Meanwhile it hands characters to a transmitter, or takes them from a receiver, one byte at a time.

On transmit, each fetched word becomes two characters, the upper byte first. On receive, characters are paired into a word, the first of each pair going to the upper byte. The block writes each pair back with one memory write. If the received stream holds an odd number of characters, the last word is written with a zero low byte. This happens when the count runs out on an odd character, and also when the receiver signals end of data early. A one-cycle done pulse closes every transfer.

Top module: `cs_packer`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req, tx_valid and rx_ready are all low.
- R2: A start pulse while idle loads start_addr and start_count, and the first memory access uses start_addr. A count of zero finishes with done and no memory access.
- R3: On transmit (start_dir=0) each word is fetched with one read request (mem_we=0). It is then offered as two characters: bits 15:8 first, bits 7:0 second.
- R4: The memory address rises by one after every granted access.
- R5: mem_req, mem_addr and mem_we stay unchanged until mem_gnt. At most one memory access is pending at a time.
- R6: While tx_ready is low, tx_valid stays high and tx_data stays unchanged, so no character is lost.
- R7: On transmit with an odd count, only the upper byte of the last word is sent.
- R8: On receive (start_dir=1) the first character of each pair is placed in bits 15:8 and the second in bits 7:0. The pair is stored with one write request (mem_we=1).
- R9: On receive with an odd count, the last word is written with bits 7:0 equal to zero.
- R10: rx_eod with half a word buffered writes that word, zero-padded in bits 7:0, and then ends. rx_eod with nothing buffered ends with no further write.
- R11: done is high for exactly one cycle after the last character or write, and busy is low in the cycle that follows.
- R12: start is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| start_dir | input | 1 | 0 = transmit, 1 = receive |
| start_addr | input | AW | First word address |
| start_count | input | CW | Number of characters |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mem_req | output | 1 | Cycle-steal request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 2*CHAR_W | Word to write |
| mem_rdata | input | 2*CHAR_W | Read word, valid with mem_gnt |
| mem_gnt | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Outgoing character available |
| tx_data | output | CHAR_W | Outgoing character |
| tx_ready | input | 1 | Sink takes the character |
| rx_valid | input | 1 | Incoming character available |
| rx_data | input | CHAR_W | Incoming character |
| rx_ready | output | 1 | Block takes the character |
| rx_eod | input | 1 | Receiver signals end of data |

## Verification
The assertions assume that mem_gnt is raised only while mem_req is high, and that mem_rdata is valid in the grant cycle. They also assume the count never moves past zero. The bench's memory model grants only a pending request. It does so after zero to two cycles of delay, and drops the grant after one cycle. The transmit sink drops tx_ready on a fixed pattern to force stalls. The receive source holds each character until rx_ready is seen and raises rx_eod only after its last character, keeping it high until done.

// File: rtl/cs_packer_pkg.sv
`timescale 1ns/1ps
package cs_packer_pkg;

    localparam int PK_CHAR_W = 8;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } pk_dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TX_HI,
        ST_TX_LO,
        ST_RX_HI,
        ST_RX_LO,
        ST_WR,
        ST_DONE
    } pk_state_e;

    typedef struct packed {
        logic load_word;
        logic load_hi;
        logic load_lo;
        logic zero_lo;
    } buf_ctl_t;

    function automatic logic is_mem_state(pk_state_e s);
        return (s == ST_RD) || (s == ST_WR);
    endfunction

endpackage

// File: rtl/cs_addr_count.sv
`timescale 1ns/1ps
module cs_addr_count #(
    parameter int AW = 8,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    input  logic          dec,
    output logic [AW-1:0] addr,
    output logic          cnt_zero,
    output logic          cnt_last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
        end else if (load) begin
            addr <= load_addr;
            cnt  <= load_cnt;
        end else begin
            if (step) addr <= addr + 1'b1;
            if (dec)  cnt  <= cnt - 1'b1;
        end
    end

    assign cnt_zero = (cnt == '0);
    assign cnt_last = (cnt == ONE);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !load |=> addr == AW'($past(addr) + 1'b1)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec |-> !cnt_zero); // R2

endmodule

// File: rtl/cs_word_buf.sv
`timescale 1ns/1ps
module cs_word_buf
    import cs_packer_pkg::*;
#(
    parameter int CHAR_W = PK_CHAR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  buf_ctl_t            ctl,
    input  logic [2*CHAR_W-1:0] word_in,
    input  logic [CHAR_W-1:0]   char_in,
    output logic [2*CHAR_W-1:0] word_out
);
    logic [CHAR_W-1:0] hi_q;
    logic [CHAR_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (ctl.load_word) begin
            hi_q <= word_in[2*CHAR_W-1:CHAR_W];
            lo_q <= word_in[CHAR_W-1:0];
        end else begin
            if (ctl.load_hi) hi_q <= char_in;
            if (ctl.zero_lo)      lo_q <= '0;
            else if (ctl.load_lo) lo_q <= char_in;
        end
    end

    assign word_out = {hi_q, lo_q};

endmodule

// File: rtl/cs_packer.sv
`timescale 1ns/1ps
module cs_packer
    import cs_packer_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CW     = 12,
    parameter int CHAR_W = PK_CHAR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                start_dir,
    input  logic [AW-1:0]       start_addr,
    input  logic [CW-1:0]       start_count,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [2*CHAR_W-1:0] mem_wdata,
    input  logic [2*CHAR_W-1:0] mem_rdata,
    input  logic                mem_gnt,
    output logic                tx_valid,
    output logic [CHAR_W-1:0]   tx_data,
    input  logic                tx_ready,
    input  logic                rx_valid,
    input  logic [CHAR_W-1:0]   rx_data,
    output logic                rx_ready,
    input  logic                rx_eod
);
    localparam int WW = 2 * CHAR_W;

    pk_state_e      state, state_nx;
    buf_ctl_t       bctl;
    logic           load, step, dec, flush_set, flush_q;
    logic           cnt_zero, cnt_last;
    logic [AW-1:0]  addr;
    logic [WW-1:0]  word;

    cs_addr_count #(.AW(AW), .CW(CW)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_addr(start_addr),
        .load_cnt (start_count),
        .step     (step),
        .dec      (dec),
        .addr     (addr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    cs_word_buf #(.CHAR_W(CHAR_W)) i_buf (
        .clk     (clk),
        .rst     (rst),
        .ctl     (bctl),
        .word_in (mem_rdata),
        .char_in (rx_data),
        .word_out(word)
    );

    always_comb begin
        state_nx  = state;
        bctl      = '0;
        load      = 1'b0;
        step      = 1'b0;
        dec       = 1'b0;
        flush_set = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                load = 1'b1;
                if (start_count == '0)       state_nx = ST_DONE;
                else if (start_dir == DIR_RX) state_nx = ST_RX_HI;
                else                          state_nx = ST_RD;
            end
            ST_RD: if (mem_gnt) begin
                bctl.load_word = 1'b1;
                step           = 1'b1;
                state_nx       = ST_TX_HI;
            end
            ST_TX_HI: if (tx_ready) begin
                dec      = 1'b1;
                state_nx = cnt_last ? ST_DONE : ST_TX_LO;
            end
            ST_TX_LO: if (tx_ready) begin
                dec      = 1'b1;
                state_nx = cnt_last ? ST_DONE : ST_RD;
            end
            ST_RX_HI: begin
                if (rx_valid) begin
                    bctl.load_hi = 1'b1;
                    dec          = 1'b1;
                    if (cnt_last) begin
                        bctl.zero_lo = 1'b1;
                        state_nx     = ST_WR;
                    end else begin
                        state_nx = ST_RX_LO;
                    end
                end else if (rx_eod) begin
                    state_nx = ST_DONE;
                end
            end
            ST_RX_LO: begin
                if (rx_valid) begin
                    bctl.load_lo = 1'b1;
                    dec          = 1'b1;
                    state_nx     = ST_WR;
                end else if (rx_eod) begin
                    bctl.zero_lo = 1'b1;
                    flush_set    = 1'b1;
                    state_nx     = ST_WR;
                end
            end
            ST_WR: if (mem_gnt) begin
                step     = 1'b1;
                state_nx = (cnt_zero || flush_q) ? ST_DONE : ST_RX_HI;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            flush_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)           flush_q <= 1'b0;
            else if (flush_set) flush_q <= 1'b1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign mem_req   = is_mem_state(state);
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = addr;
    assign mem_wdata = word;
    assign tx_valid  = (state == ST_TX_HI) || (state == ST_TX_LO);
    assign tx_data   = (state == ST_TX_HI) ? word[WW-1:CHAR_W] : word[CHAR_W-1:0];
    assign rx_ready  = (state == ST_RX_HI) || (state == ST_RX_LO);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R5

    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !tx_valid && !rx_ready); // R1

endmodule

// File: tb/test_cs_packer.sv
`timescale 1ns/1ps
module test_cs_packer;
    localparam int AW = 8;
    localparam int CW = 12;
    localparam int CH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           start_dir = 1'b0;
    logic [AW-1:0]  start_addr = '0;
    logic [CW-1:0]  start_count = '0;
    logic           busy, done, mem_req, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [2*CH-1:0] mem_wdata;
    logic [2*CH-1:0] mem_rdata = '0;
    logic           mem_gnt = 1'b0;
    logic           tx_valid;
    logic [CH-1:0]  tx_data;
    logic           tx_ready = 1'b0;
    logic           rx_valid = 1'b0;
    logic [CH-1:0]  rx_data = '0;
    logic           rx_ready;
    logic           rx_eod = 1'b0;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    string wr_tag = "R8";

    logic [CH-1:0]      exp_tx[$];
    logic [AW+2*CH-1:0] exp_wr[$];
    logic [2*CH-1:0]    mem [0:63];

    always #2.5 clk = ~clk;

    cs_packer #(.AW(AW), .CW(CW), .CHAR_W(CH)) i_cs_packer (
        .clk(clk), .rst(rst), .start(start), .start_dir(start_dir),
        .start_addr(start_addr), .start_count(start_count),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_eod(rx_eod)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // memory model: grants after 0..2 cycles, one-cycle grant pulse
    int gwait = 0;
    int gsel = 0;
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++)
                mem[i] = {8'(i * 3 + 1), 8'(8'hC0 ^ i)};
            mem_gnt = 1'b0;
        end else if (mem_gnt) begin
            mem_gnt = 1'b0;
        end else if (mem_req) begin
            if (gwait != 0) begin
                gwait--;
            end else begin
                mem_gnt = 1'b1;
                gsel++;
                gwait = gsel % 3;
                if (mem_we) begin
                    wr_seen++;
                    if (exp_wr.size() == 0) begin
                        chk(1'b0, wr_tag, "unexpected write", 32'({mem_addr, mem_wdata}), 32'h0);
                    end else begin
                        logic [AW+2*CH-1:0] e;
                        e = exp_wr.pop_front();
                        chk(e == {mem_addr, mem_wdata}, wr_tag, "write addr/data",
                            32'({mem_addr, mem_wdata}), 32'(e));
                    end
                    mem[mem_addr[5:0]] = mem_wdata;
                end else begin
                    rd_seen++;
                    mem_rdata = mem[mem_addr[5:0]];
                end
            end
        end
    end

    // transmit sink / scoreboard monitor
    int  rdy_ctr = 0;
    bit  prev_v = 0, prev_r = 0;
    logic [CH-1:0] prev_d = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_v && !prev_r)   // R6 stall holds character
                chk(tx_valid && tx_data == prev_d, "R6", "held char",
                    32'({tx_valid, tx_data}), 32'({1'b1, prev_d}));
            rdy_ctr++;
            tx_ready = (rdy_ctr % 4) != 2;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    chk(1'b0, "R3", "unexpected char", 32'(tx_data), 32'h0);
                end else begin
                    logic [CH-1:0] e;
                    e = exp_tx.pop_front();
                    chk(e == tx_data, "R3", "char order", 32'(tx_data), 32'(e));
                end
            end
            prev_v = tx_valid;
            prev_r = tx_ready;
            prev_d = tx_data;
        end
    end

    task automatic pulse_start(input bit dir, input int addr, input int cnt);
        start = 1'b1; start_dir = dir;
        start_addr = AW'(addr); start_count = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done, tag, "done seen", 32'(done), 32'h1);
        @(negedge clk);
        chk(!done && !busy, "R11", "done one cycle then idle", 32'({done, busy}), 32'h0);
        chk(exp_tx.size() == 0, tag, "chars left", 32'(exp_tx.size()), 32'h0);
        chk(exp_wr.size() == 0, tag, "writes left", 32'(exp_wr.size()), 32'h0);
    endtask

    // driver: push expected characters, then start a transmit
    task automatic run_tx(input int addr, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            logic [2*CH-1:0] w;
            w = mem[(addr + k / 2) % 64];
            exp_tx.push_back((k % 2 == 0) ? w[2*CH-1:CH] : w[CH-1:0]);
        end
        pulse_start(1'b0, addr, cnt);
    endtask

    // driver: push expected writes, then feed characters
    task automatic run_rx(input int addr, input int cnt, input int n_send,
                          input int seed, input string tag);
        logic [CH-1:0] c [0:31];
        for (int j = 0; j < n_send; j++) c[j] = 8'(8'h31 + 7 * j + seed);
        for (int p = 0; 2 * p < n_send; p++) begin
            logic [CH-1:0] lo;
            lo = (2 * p + 1 < n_send) ? c[2 * p + 1] : 8'h00;
            exp_wr.push_back({AW'(addr + p), c[2 * p], lo});
        end
        wr_tag = tag;
        pulse_start(1'b1, addr, cnt);
        for (int j = 0; j < n_send; j++) begin
            rx_valid = 1'b1;
            rx_data  = c[j];
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (n_send < cnt) rx_eod = 1'b1;
        wait_done(tag);
        rx_eod = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        int r0, w0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done after reset", 32'({busy, done}), 32'h0);
        chk(!mem_req && !tx_valid && !rx_ready, "R1", "outputs after reset",
            32'({mem_req, tx_valid, rx_ready}), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R3/R4: even transmit, three words from address 4
        r0 = rd_seen;
        run_tx(4, 6);
        wait_done("R3");
        chk(rd_seen - r0 == 3, "R4", "read count", 32'(rd_seen - r0), 32'd3);

        // R7: odd transmit, last word only upper byte
        run_tx(20, 5);
        wait_done("R7");
        chk(!tx_valid, "R7", "no extra char", 32'(tx_valid), 32'h0);

        // R8: even receive
        run_rx(30, 4, 4, 0, "R8");
        chk(mem[30] == {8'h31, 8'h38}, "R8", "stored word", 32'(mem[30]), 32'h3138);

        // R9: odd receive, zero low byte
        run_rx(40, 3, 3, 5, "R9");
        chk(mem[41][7:0] == 8'h00, "R9", "pad byte", 32'(mem[41]), 32'h0);

        // R10: end of data with half word buffered
        run_rx(48, 10, 3, 9, "R10");
        // R10: end of data on a word boundary
        w0 = wr_seen;
        run_rx(52, 10, 2, 2, "R10");
        chk(wr_seen - w0 == 1, "R10", "writes on boundary eod", 32'(wr_seen - w0), 32'd1);

        // R2: zero count, no memory access
        r0 = rd_seen; w0 = wr_seen;
        pulse_start(1'b0, 8, 0);
        wait_done("R2");
        chk(rd_seen == r0 && wr_seen == w0, "R2", "zero count accesses",
            32'(rd_seen - r0 + wr_seen - w0), 32'h0);

        // R12: start while busy is ignored
        r0 = rd_seen;
        run_tx(10, 4);
        repeat (3) @(negedge clk);
        chk(busy, "R12", "busy during transfer", 32'(busy), 32'h1);
        wr_tag = "R12";
        pulse_start(1'b1, 44, 2);
        wait_done("R12");
        chk(rd_seen - r0 == 2, "R12", "reads of first transfer", 32'(rd_seen - r0), 32'd2);

        summary();
    end
endmodule